// File: doc/BRIEF.md
# Tunable Capacitor Serial Control Slave

This block is the receiving end of a three-wire serial control port. It sets a 4-bit tuning state and a standby flag. The port has a serial clock, a serial data line and an enable line that is high during a transfer. While the enable is high, every rising edge of the serial clock moves one data bit into an eight-bit shift register, most significant bit first. The block does not count bits. The shift register always holds the last eight bits it received. When the enable falls, the block decodes that word into a latched output register, and those outputs hold until the next falling edge of the enable.

The serial lines are brought onto a fast system clock through a parameterised synchroniser. Setting `SYNC_STAGES` to 0 samples the lines directly, with no synchroniser flops. A control module turns the edges it detects into two strobes, shift and latch, which go to a datapath module. The datapath owns the shift register, the output fields and a sticky flag that reports a word written with nonzero reserved bits.

Top module: `tcap_ctrl_slave`

## Requirements
- R1: While the enable is high, each rising edge of the serial clock shifts the data bit in at the least significant end. The first bit sent ends up as word bit 7.
- R2: The latched outputs change only after a falling edge of the enable. They hold their values while a transfer is in progress.
- R3: The block keeps no bit count. After more than eight bits, the last eight are latched. After fewer than eight, the bits already in the shift register fill the upper positions.
- R4: In the latched word, bits 3..0 give the tuning state and bit 5 gives standby, where 1 means standby. The active output is the inverse of standby.
- R5: Word bits 7, 6 and 4 are reserved. A latched word with any of them at 1 sets the error flag, and the error flag stays set until reset. The state and standby fields of that word are still applied.
- R6: Serial clock edges are ignored while the enable is low. The shift register keeps its contents between transfers.
- R7: Reset sets the tuning state, standby, error flag and shift register to 0, and active to 1.
- R8: A serial clock rising edge that is seen in the same system cycle as the enable's falling edge is still shifted in, and it is part of the word that gets latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial clock |
| serData | input | 1 | Serial data |
| serEn | input | 1 | Serial enable, active high |
| tuneState | output | 4 | Latched tuning state |
| standby | output | 1 | Latched standby flag |
| active | output | 1 | High when not in standby |
| rsvdErr | output | 1 | Sticky reserved-bit error |

## Verification
The serial clock and the enable go through synchroniser stages of equal depth. Because of that, the last clock rising edge and the enable's falling edge can reach the control in the same system cycle, and the control then raises the shift strobe and the latch strobe together. The bench provokes this by driving the eighth rising edge and the enable fall on the same clock edge. It then expects a tuning state in which the eighth bit is present. If that bit were dropped or arrived one cycle late, the word would differ.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int WORD_W    = 8;
  localparam int STATE_W   = 4;
  localparam int STBY_POS  = 5;
  localparam logic [WORD_W-1:0] RSVD_MASK = 8'b1101_0000;

  typedef struct packed {
    logic shift;
    logic latch;
  } strobe_t;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_direct
      assign dout = din;
    end else begin : g_flops
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= din;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkCur,
  input  logic    senCur,
  output strobe_t strobes
);
  logic sclkPrev;
  logic senPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      senPrev  <= 1'b0;
    end else begin
      sclkPrev <= sclkCur;
      senPrev  <= senCur;
    end
  end

  // Enable state of the previous sample qualifies the shift, so an edge
  // coinciding with the enable fall still counts.
  always_comb begin
    strobes.shift = sclkCur & ~sclkPrev & senPrev;
    strobes.latch = senPrev & ~senCur;
  end
endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic               bitIn,
  output logic [STATE_W-1:0] tuneState,
  output logic               standby,
  output logic               rsvdErr
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;

  assign nextWord = strobes.shift ? {shiftReg[WORD_W-2:0], bitIn} : shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      tuneState <= '0;
      standby   <= 1'b0;
      rsvdErr   <= 1'b0;
    end else begin
      shiftReg <= nextWord;
      if (strobes.latch) begin
        tuneState <= nextWord[STATE_W-1:0];
        standby   <= nextWord[STBY_POS];
        rsvdErr   <= rsvdErr | (|(nextWord & RSVD_MASK));
      end
    end
  end
endmodule

// File: rtl/tcap_ctrl_slave.sv
module tcap_ctrl_slave
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serEn,
  output logic [STATE_W-1:0] tuneState,
  output logic               standby,
  output logic               active,
  output logic               rsvdErr
);
  logic [2:0] syncOut;
  strobe_t    strobes;

  tcap_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({serEn, serClk, serData}),
    .dout(syncOut)
  );

  tcap_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclkCur(syncOut[1]),
    .senCur (syncOut[2]),
    .strobes(strobes)
  );

  tcap_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bitIn    (syncOut[0]),
    .tuneState(tuneState),
    .standby  (standby),
    .rsvdErr  (rsvdErr)
  );

  assign active = ~standby;
endmodule

// File: rtl/tcap_ctrl_checker.sv
module tcap_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       latchStb,
  input logic [3:0] tuneState,
  input logic       standby,
  input logic       rsvdErr
);
  // R2: outputs move only in the cycle after a latch strobe
  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !latchStb |=> ($stable(tuneState) && $stable(standby)));

  // R5: error flag is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rsvdErr |=> rsvdErr);

  // R5: error flag rises only as a result of a latch
  a_r5_err_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rsvdErr) |-> $past(latchStb));

  // R2: latch is a single-cycle pulse per enable fall
  a_r2_latch_pulse: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |=> !latchStb);
endmodule

bind tcap_ctrl_slave tcap_ctrl_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .latchStb (strobes.latch),
  .tuneState(tuneState),
  .standby  (standby),
  .rsvdErr  (rsvdErr)
);

// File: tb/tb_tcap_ctrl_slave.sv
module tb_tcap_ctrl_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serEn = 1'b0;
  logic [3:0] tuneState;
  logic standby, active, rsvdErr;

  int applied = 0;
  int failed = 0;

  always #10 clk = ~clk;

  tcap_ctrl_slave dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serEn(serEn),
    .tuneState(tuneState), .standby(standby), .active(active), .rsvdErr(rsvdErr)
  );

  // {expErr, expStby, expState[3:0], nbits[4:0], payload[15:0]}
  localparam int NV = 6;
  localparam logic [26:0] VECS [NV] = '{
    {1'b0, 1'b0, 4'h5, 5'd8,  16'h0005},  // R1 R4 plain word
    {1'b0, 1'b1, 4'hF, 5'd8,  16'h002F},  // R4 standby
    {1'b0, 1'b0, 4'h0, 5'd8,  16'h0000},  // R4 back to active, min state
    {1'b0, 1'b0, 4'h9, 5'd16, 16'hA309},  // R3 over-length: last 8 = 0x09
    {1'b1, 1'b0, 4'hA, 5'd12, 16'h0CCA},  // R3 R5 last 8 = 0xCA, reserved set
    {1'b1, 1'b1, 4'h3, 5'd8,  16'h0023}   // R5 flag stays set
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    applied++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startTx();
    serEn = 1'b1;
    waitClk(4);
  endtask

  task automatic sendBits(input logic [15:0] payload, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serClk = 1'b0;
      serData = payload[i];
      waitClk(4);
      serClk = 1'b1;
      waitClk(4);
    end
  endtask

  task automatic endTx();
    serEn = 1'b0;
    waitClk(8);
    serClk = 1'b0;
    waitClk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    waitClk(3);
    // R7 reset state
    check("R7 state", {4'h0, tuneState}, 8'h00);
    check("R7 standby", {7'h0, standby}, 8'h00);
    check("R7 active", {7'h0, active}, 8'h01);
    check("R7 err", {7'h0, rsvdErr}, 8'h00);
    rstN = 1'b1;
    waitClk(3);

    for (int v = 0; v < NV; v++) begin
      startTx();
      sendBits(VECS[v][15:0], int'(VECS[v][20:16]));
      endTx();
      check("R1 R3 R4 state", {4'h0, tuneState}, {4'h0, VECS[v][24:21]});
      check("R4 standby", {7'h0, standby}, {7'h0, VECS[v][25]});
      check("R4 active", {7'h0, active}, {7'h0, ~VECS[v][25]});
      check("R5 err", {7'h0, rsvdErr}, {7'h0, VECS[v][26]});
    end

    // R2: outputs hold mid-transfer (last latched: state 3, standby 1)
    startTx();
    sendBits(16'h0007, 8);
    check("R2 hold state", {4'h0, tuneState}, 8'h03);
    check("R2 hold standby", {7'h0, standby}, 8'h01);
    endTx();
    check("R2 applied at fall", {4'h0, tuneState}, 8'h07);

    // R7 mid-run reset clears error and shift register
    rstN = 1'b0;
    waitClk(2);
    check("R7 err cleared", {7'h0, rsvdErr}, 8'h00);
    check("R7 state cleared", {4'h0, tuneState}, 8'h00);
    rstN = 1'b1;
    waitClk(3);

    // R6: clock edges with enable low are ignored
    serEn = 1'b0;
    sendBits(16'h00FF, 8);
    serClk = 1'b0;
    waitClk(8);
    check("R6 state unchanged", {4'h0, tuneState}, 8'h00);
    // R3 R6: only four bits sent; upper bits come from the (still zero) register
    startTx();
    sendBits(16'h0006, 4);
    endTx();
    check("R3 R6 short word state", {4'h0, tuneState}, 8'h06);
    check("R6 no stray reserved", {7'h0, rsvdErr}, 8'h00);
    check("R6 no stray standby", {7'h0, standby}, 8'h00);

    // R8: eighth rising edge coincides with enable fall
    startTx();
    sendBits(16'h0005, 7);   // 0000101
    serClk = 1'b0;
    serData = 1'b1;
    waitClk(4);
    serClk = 1'b1;
    serEn = 1'b0;
    waitClk(8);
    serClk = 1'b0;
    waitClk(2);
    check("R8 coincident bit", {4'h0, tuneState}, 8'h0B);
    check("R8 err", {7'h0, rsvdErr}, 8'h00);

    // R5: only bit 4 set, fields still applied
    startTx();
    sendBits(16'h0012, 8);
    endTx();
    check("R5 bit4 err", {7'h0, rsvdErr}, 8'h01);
    check("R5 fields applied", {4'h0, tuneState}, 8'h02);

    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule